// File: doc/BRIEF.md
# Residual Sample Counter with Selectable Gate

This block ends a data acquisition after a programmed number of conversions. Software loads a count N. An arm control enables the block, and two mode controls (a post-count mode bit and a pre-trigger enable) pick the strobe that opens the counting gate. The choices are the external trigger, the first conversion, or a FIFO half-full event. While the gate is open and the block is armed, each conversion strobe counts the value down. When a counted conversion reaches terminal count, the block raises a stop level. Acquisition control holds off further conversions for as long as that level is high.

The block is meant for both pre-trigger and post-trigger captures. In a pre-trigger capture the count starts at the external trigger. In a plain post-trigger capture the count starts at the first conversion. When N is larger than half the FIFO, the count starts at a half-full event. The gate, the stop level and the remaining count are registered outputs.

Top module: `rsc_residual_counter`

## Requirements
- R1: A cycle with `load_i` high sets `count_o` to `load_val_i`, closes `gate_o` and clears `stop_o` at the next edge. Load takes priority over every strobe in the same cycle.
- R2: With `postmode_i`=1 and `pretrig_i`=1, a `trig_i` strobe seen while armed opens `gate_o` at the next edge.
- R3: With `postmode_i`=1 and `pretrig_i`=0, a `conv_i` strobe seen while armed opens `gate_o` at the next edge. That opening conversion is not counted.
- R4: With `postmode_i`=0, a `half_i` strobe seen while armed opens `gate_o` at the next edge, whatever `pretrig_i` is.
- R5: A strobe that the current mode does not select leaves `gate_o` closed and `count_o` unchanged.
- R6: While `armed_i`=0, no strobe opens the gate and no conversion changes `count_o`.
- R7: With `gate_o` already high, `armed_i`=1 and `stop_o` low, each `conv_i` strobe lowers `count_o` by exactly one at the next edge.
- R8: A counted conversion that finds `count_o` at 1 or 0 sets `stop_o` and leaves `count_o` at 0. A load value of 0 therefore stops on the first counted conversion.
- R9: `stop_o` stays high, and `count_o` stays at 0, through any later strobes until the next load.
- R10: Once open, `gate_o` stays high until a load or reset, including across mode changes.
- R11: Synchronous reset drives `gate_o`, `stop_o` and `count_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load strobe for the count value |
| load_val_i | input | CNT_W | Count value N |
| armed_i | input | 1 | Arm control; enables gate latching and counting |
| postmode_i | input | 1 | 1: gate on trigger or first conversion; 0: gate on FIFO half-full |
| pretrig_i | input | 1 | Pre-trigger enable (used when `postmode_i`=1) |
| conv_i | input | 1 | ADC conversion strobe |
| half_i | input | 1 | FIFO half-full strobe |
| trig_i | input | 1 | External trigger strobe |
| gate_o | output | 1 | Counter gate is latched open |
| stop_o | output | 1 | Terminal count reached; acquisition must stop |
| count_o | output | CNT_W | Remaining count |

## Verification
All three pieces of state in this block are port registers. A wrong gate, count or stop value therefore shows at the ports at the edge that follows the faulty decision. If the strobe selection is wrong, `gate_o` rises one cycle after a strobe that should have been ignored, or it fails to rise. If the down-counter is wrong, `count_o` slips by one on the next counted conversion, and `stop_o` comes one conversion early or late. A stop level that is not sticky shows as `stop_o` falling, or `count_o` moving, on the next conversion after terminal count.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {
    SRC_HALF  = 2'd0,
    SRC_CONV  = 2'd1,
    SRC_TRIG  = 2'd2
  } gate_src_e;

  function automatic gate_src_e pick_src(input logic postmode, input logic pretrig);
    if (!postmode)    return SRC_HALF;
    else if (pretrig) return SRC_TRIG;
    else              return SRC_CONV;
  endfunction
endpackage

// File: rtl/rsc_gate_sel.sv
module rsc_gate_sel
  import rsc_pkg::*;
(
  input  logic postmode_i,
  input  logic pretrig_i,
  input  logic conv_i,
  input  logic half_i,
  input  logic trig_i,
  output logic open_stb_o
);
  gate_src_e src;

  always_comb begin
    src = pick_src(postmode_i, pretrig_i);
    unique case (src)
      SRC_HALF: open_stb_o = half_i;
      SRC_CONV: open_stb_o = conv_i;
      SRC_TRIG: open_stb_o = trig_i;
      default:  open_stb_o = 1'b0;
    endcase
  end

  // R5: only the selected strobe may request the gate
  always_comb begin
    if (open_stb_o) begin
      a_r5_selected_only: assert ((postmode_i && pretrig_i && trig_i) ||
                                  (postmode_i && !pretrig_i && conv_i) ||
                                  (!postmode_i && half_i));
    end
  end
endmodule

// File: rtl/rsc_gate_latch.sv
module rsc_gate_latch (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic armed_i,
  input  logic open_stb_i,
  output logic gate_o
);
  always_ff @(posedge clk) begin
    if (rst)                              gate_o <= 1'b0;
    else if (load_i)                      gate_o <= 1'b0;
    else if (armed_i && open_stb_i)       gate_o <= 1'b1;
  end

  a_r10_gate_holds: assert property (@(posedge clk) disable iff (rst)
    gate_o && !load_i |=> gate_o);
  a_r1_load_closes: assert property (@(posedge clk) disable iff (rst)
    load_i |=> !gate_o);
  a_r6_no_latch_unarmed: assert property (@(posedge clk) disable iff (rst)
    !gate_o && !armed_i |=> !gate_o);
endmodule

// File: rtl/rsc_count.sv
module rsc_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             armed_i,
  input  logic             gate_i,
  input  logic             conv_i,
  output logic [CNT_W-1:0] count_o,
  output logic             stop_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic counted;
  logic at_term;

  assign counted = gate_i && armed_i && conv_i && !stop_o;
  assign at_term = (count_o <= ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
      stop_o  <= 1'b0;
    end else if (load_i) begin
      count_o <= load_val_i;
      stop_o  <= 1'b0;
    end else if (counted) begin
      if (at_term) begin
        count_o <= '0;
        stop_o  <= 1'b1;
      end else begin
        count_o <= count_o - ONE;
      end
    end
  end

  a_r9_stop_sticky: assert property (@(posedge clk) disable iff (rst)
    stop_o && !load_i |=> stop_o && count_o == '0);
  a_r7_no_increase: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> count_o <= $past(count_o));
  a_r6_hold_unarmed: assert property (@(posedge clk) disable iff (rst)
    !armed_i && !load_i |=> $stable(count_o) && $stable(stop_o));
  a_r1_load_value: assert property (@(posedge clk) disable iff (rst)
    load_i |=> count_o == $past(load_val_i) && !stop_o);
  a_r8_stop_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_o) |-> count_o == '0);
endmodule

// File: rtl/rsc_residual_counter.sv
module rsc_residual_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             armed_i,
  input  logic             postmode_i,
  input  logic             pretrig_i,
  input  logic             conv_i,
  input  logic             half_i,
  input  logic             trig_i,
  output logic             gate_o,
  output logic             stop_o,
  output logic [CNT_W-1:0] count_o
);
  logic open_stb;

  rsc_gate_sel u_sel (
    .postmode_i (postmode_i),
    .pretrig_i  (pretrig_i),
    .conv_i     (conv_i),
    .half_i     (half_i),
    .trig_i     (trig_i),
    .open_stb_o (open_stb)
  );

  rsc_gate_latch u_gate (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_i),
    .armed_i    (armed_i),
    .open_stb_i (open_stb),
    .gate_o     (gate_o)
  );

  rsc_count #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .armed_i    (armed_i),
    .gate_i     (gate_o),
    .conv_i     (conv_i),
    .count_o    (count_o),
    .stop_o     (stop_o)
  );

  // R3: the conversion that opens the gate is not counted
  a_r3_open_not_counted: assert property (@(posedge clk) disable iff (rst)
    !gate_o && !load_i |=> $stable(count_o));
endmodule

// File: tb/rsc_residual_counter_tb.sv
module rsc_residual_counter_tb;
  localparam int CNT_W = 16;
  localparam int NV = 26;

  logic clk = 1'b0;
  logic rst, load_i, armed_i, postmode_i, pretrig_i, conv_i, half_i, trig_i;
  logic [CNT_W-1:0] load_val_i;
  logic gate_o, stop_o;
  logic [CNT_W-1:0] count_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rsc_residual_counter #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .load_i(load_i), .load_val_i(load_val_i),
    .armed_i(armed_i), .postmode_i(postmode_i), .pretrig_i(pretrig_i),
    .conv_i(conv_i), .half_i(half_i), .trig_i(trig_i),
    .gate_o(gate_o), .stop_o(stop_o), .count_o(count_o)
  );

  // fields: ld, val[16], ar, pm, pt, cv, hf, tg, exp gate, exp stop, exp count[16]
  localparam logic [40:0] VEC [NV] = '{
    {1'b1,16'd3,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'd3}, // R1
    {1'b0,16'd0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,16'd3}, // R5 conv
    {1'b0,16'd0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,16'd3}, // R5 half
    {1'b0,16'd0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,16'd3}, // R6 trig unarmed
    {1'b0,16'd0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,16'd3}, // R2
    {1'b0,16'd0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,16'd2}, // R7
    {1'b0,16'd0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,16'd2}, // R6 hold
    {1'b0,16'd0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,16'd1}, // R7
    {1'b0,16'd0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,16'd1}, // R7 idle
    {1'b0,16'd0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,16'd0}, // R8
    {1'b0,16'd0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,16'd0}, // R9
    {1'b1,16'd2,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'd2}, // R1
    {1'b0,16'd0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,16'd2}, // R5 trig
    {1'b0,16'd0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,16'd2}, // R3
    {1'b0,16'd0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,16'd1}, // R7
    {1'b0,16'd0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,16'd0}, // R8
    {1'b1,16'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'd0}, // R1
    {1'b0,16'd0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,16'd0}, // R5 conv
    {1'b0,16'd0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,16'd0}, // R4 trig ignored
    {1'b0,16'd0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,16'd0}, // R4
    {1'b0,16'd0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,16'd0}, // R8 N=0
    {1'b1,16'd5,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,16'd5}, // R1 priority
    {1'b0,16'd0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,16'd5}, // R4 open not counted
    {1'b0,16'd0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,16'd5}, // R10 mode change
    {1'b1,16'd1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,16'd1}, // R1 reload closes
    {1'b0,16'd0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,16'd1}  // R4
  };

  task automatic drive(input logic [40:0] v);
    {load_i, load_val_i, armed_i, postmode_i, pretrig_i, conv_i, half_i, trig_i} = v[40:18];
  endtask

  task automatic check(input string req, input logic eg, input logic es,
                       input logic [CNT_W-1:0] ec);
    n_vec++;
    if (gate_o !== eg || stop_o !== es || count_o !== ec) begin
      n_bad++;
      $display("FAIL %s: gate/stop/count = %0b/%0b/%0d, expected %0b/%0b/%0d",
               req, gate_o, stop_o, count_o, eg, es, ec);
    end
  endtask

  task automatic step(input logic [40:0] v);
    drive(v);
    @(negedge clk);
  endtask

  localparam logic [40:0] IDLE = '0;

  initial begin
    drive(IDLE);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R11 reset", 1'b0, 1'b0, '0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i]);
      check($sformatf("vector %0d", i), VEC[i][17], VEC[i][16], VEC[i][15:0]);
    end

    // R9: stop persists over many conversions
    step({1'b0,16'd0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,16'd0}); // count 1 -> stop
    for (int k = 0; k < 5; k++)
      step({1'b0,16'd0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,16'd0});
    check("R9 sticky stop", 1'b1, 1'b1, '0);

    // R7: long run from max count, trigger mode
    step({1'b1,16'hFFFF,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'd0});
    step({1'b0,16'd0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,16'd0});
    for (int k = 0; k < 100; k++)
      step({1'b0,16'd0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,16'd0});
    check("R7 long run", 1'b1, 1'b0, 16'hFFFF - 16'd100);

    // R11: reset mid-run
    rst = 1'b1;
    step(IDLE);
    rst = 1'b0;
    check("R11 reset mid-run", 1'b0, 1'b0, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule